// File: doc/BRIEF.md
# Low-Power Sleep and Wake-Up Controller

This block takes the device from its run state into one of three sleep depths when an idle command arrives. It then decides which events may bring it back to run. The three depths, from most to least power, are light, mid and deep. A 2-bit mode input, sampled together with the idle command, picks the depth. While the block sleeps it drives the run enables of two countdown timers. It raises a one-clock wake pulse on the cycle it returns to run.

Each depth allows a different set of wake sources:

- **Timers.** Each timer can wake the block through its underflow flag, but only if it was running and its mask bit is set. Deep sleep halts both timers, so a timed wake-up is not possible from deep.
- **External pins.** The sources are the eight pins of port F and four pins of port D (pins 2 to 5). A D pin counts only while it is configured as an input. Each pin wakes on the edge selected for it, rising or falling, and only when both its mask bit and the global arm bit are set.
- **Reset line.** A low-to-high transition always wakes the block.
- **DAC-timer event.** It wakes the block only while the power-down-mode bit is set.

External pins and the reset line pass through two synchronizer flops. Edges are found on the synchronized values. Events seen while the block is in run are discarded.

Top module: `lpm_wake_ctrl`

## Requirements
- R1: After reset, `sleep_state_o` is 0 (run), `wake_o` is 0 and `tmr_en_o` equals `tmr_run_i`.
- R2: `idle_i` high in run is sampled at a clock edge, and `sleep_state_o` then shows the depth. Mode code 0 gives 1 (light), code 1 gives 2 (mid), and codes 2 and 3 give 3 (deep). `idle_i` while asleep changes nothing.
- R3: In light and mid sleep `tmr_en_o[k]` equals `tmr_run_i[k]`. In deep sleep `tmr_en_o` is all zero.
- R4: In light or mid sleep, `tmr_uflow_i[k]` raises `wake_o` one cycle later and the state returns to 0. This requires mask bit k (bit 0 for timer 0, bit 1 for timer 1) and `tmr_run_i[k]` to be set. If either is clear, the underflow does not wake.
- R5: In deep sleep no timer underflow causes a wake-up, whatever the mask.
- R6: External source i wakes any sleep depth when mask bit 2+i and `arm_i` are both set. Sources 0 to 7 are `port_f_i[7:0]` and sources 8 to 11 are `port_d_i[3:0]`. `wake_o` rises three clock edges after the pin changes. If `arm_i` is clear, no pin wakes.
- R7: `edge_sel_i[i]` = 0 selects a rising edge for source i and 1 selects a falling edge. The opposite edge does not wake.
- R8: A D pin whose `port_d_dir_i` bit is 1 (output) never wakes.
- R9: A rising edge on `reset_line_i` wakes any depth, whatever the masks and arm bit, three clock edges after it occurs.
- R10: `dac_evt_i` wakes any depth one cycle later when `pdm_i` is 1. It never wakes when `pdm_i` is 0.
- R11: `wake_o` is high for exactly one cycle, in the first run cycle after sleep. Events seen while in run produce no wake pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| idle_i | input | 1 | Idle command, enters sleep |
| sleep_mode_i | input | 2 | Depth select sampled with idle |
| tmr_run_i | input | 2 | Timers running before idle |
| tmr_uflow_i | input | 2 | Timer underflow flags |
| port_f_i | input | 8 | External F port pins |
| port_d_i | input | 4 | D port pins 2 to 5 |
| port_d_dir_i | input | 4 | D pin direction, 1 = output |
| edge_sel_i | input | 12 | Per-source edge select, 1 = falling |
| irq_mask_i | input | 14 | Mask: [1:0] timers, [13:2] external sources |
| arm_i | input | 1 | Global arm for external wake |
| reset_line_i | input | 1 | Reset line, rising edge wakes |
| dac_evt_i | input | 1 | DAC-timer event |
| pdm_i | input | 1 | Power-down-mode bit |
| sleep_state_o | output | 2 | 0 run, 1 light, 2 mid, 3 deep |
| tmr_en_o | output | 2 | Timer run enables |
| wake_o | output | 1 | One-cycle wake pulse |

## Verification
The assertions check on every cycle that:

- the wake pulse lasts a single cycle and appears only on a sleep-to-run transition;
- the run state is left only on an idle command;
- the timer enables follow the depth;
- a qualified timer underflow in light or mid wakes the block;
- deep sleep never wakes without an external, reset-line or DAC hit.

Only the bench scenarios can show the full chain through the synchronizers:

- the three-edge pin latency;
- edge polarity;
- the direction and arm qualifiers;
- the mode decode;
- the fact that events during run are dropped.

// File: rtl/lpm_wake_pkg.sv
package lpm_wake_pkg;
  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_LIGHT = 2'd1,
    ST_MID   = 2'd2,
    ST_DEEP  = 2'd3
  } sleep_st_e;

  function automatic sleep_st_e f_depth(input logic [1:0] mode);
    case (mode)
      2'd0:    return ST_LIGHT;
      2'd1:    return ST_MID;
      default: return ST_DEEP;
    endcase
  endfunction

  function automatic logic f_edge(input logic cur, input logic prev, input logic fall);
    return fall ? (prev & ~cur) : (cur & ~prev);
  endfunction

  function automatic logic f_timers_live(input sleep_st_e st);
    return (st != ST_DEEP);
  endfunction
endpackage

// File: rtl/lpm_edge_sync.sv
module lpm_edge_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_i,
  input  logic [W-1:0] fall_sel_i,
  output logic [W-1:0] edge_o
);
  import lpm_wake_pkg::*;

  logic [STAGES-1:0][W-1:0] sync_q;
  logic [W-1:0]             prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q[0] <= '0;
    else        sync_q[0] <= pin_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q[s] <= '0;
      else        sync_q[s] <= sync_q[s-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= sync_q[STAGES-1];
  end

  for (genvar i = 0; i < W; i++) begin : g_edge
    assign edge_o[i] = f_edge(sync_q[STAGES-1][i], prev_q[i], fall_sel_i[i]);
  end
endmodule

// File: rtl/lpm_wake_src.sv
module lpm_wake_src #(
  parameter int NUM_TMR = 2,
  parameter int NEXT    = 12
) (
  input  lpm_wake_pkg::sleep_st_e state_i,
  input  logic [NUM_TMR-1:0]      tmr_en_i,
  input  logic [NUM_TMR-1:0]      tmr_uflow_i,
  input  logic [NEXT-1:0]         ext_edge_i,
  input  logic [NEXT-1:0]         ext_is_in_i,
  input  logic [NUM_TMR+NEXT-1:0] mask_i,
  input  logic                    arm_i,
  input  logic                    rst_edge_i,
  input  logic                    dac_evt_i,
  input  logic                    pdm_i,
  output logic                    tmr_hit_o,
  output logic                    ext_hit_o,
  output logic                    rst_hit_o,
  output logic                    dac_hit_o,
  output logic                    wake_req_o
);
  import lpm_wake_pkg::*;

  logic asleep;
  assign asleep = (state_i != ST_RUN);

  assign tmr_hit_o = asleep && f_timers_live(state_i) &&
                     (|(tmr_uflow_i & tmr_en_i & mask_i[NUM_TMR-1:0]));
  assign ext_hit_o = asleep && arm_i &&
                     (|(ext_edge_i & ext_is_in_i & mask_i[NUM_TMR+NEXT-1:NUM_TMR]));
  assign rst_hit_o = asleep && rst_edge_i;
  assign dac_hit_o = asleep && pdm_i && dac_evt_i;

  assign wake_req_o = tmr_hit_o | ext_hit_o | rst_hit_o | dac_hit_o;
endmodule

// File: rtl/lpm_sleep_fsm.sv
module lpm_sleep_fsm (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    idle_i,
  input  logic [1:0]              mode_i,
  input  logic                    wake_req_i,
  output lpm_wake_pkg::sleep_st_e state_o,
  output logic                    wake_o
);
  import lpm_wake_pkg::*;

  sleep_st_e state_q, state_d;
  logic      wake_d;

  always_comb begin
    state_d = state_q;
    wake_d  = 1'b0;
    if (state_q == ST_RUN) begin
      if (idle_i) state_d = f_depth(mode_i);
    end else if (wake_req_i) begin
      state_d = ST_RUN;
      wake_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_RUN;
      wake_o  <= 1'b0;
    end else begin
      state_q <= state_d;
      wake_o  <= wake_d;
    end
  end

  assign state_o = state_q;
endmodule

// File: rtl/lpm_wake_ctrl.sv
module lpm_wake_ctrl #(
  parameter int NUM_TMR     = 2,
  parameter int F_W         = 8,
  parameter int D_W         = 4,
  parameter int SYNC_STAGES = 2,
  localparam int NEXT       = F_W + D_W,
  localparam int MASK_W     = NUM_TMR + NEXT
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               idle_i,
  input  logic [1:0]         sleep_mode_i,
  input  logic [NUM_TMR-1:0] tmr_run_i,
  input  logic [NUM_TMR-1:0] tmr_uflow_i,
  input  logic [F_W-1:0]     port_f_i,
  input  logic [D_W-1:0]     port_d_i,
  input  logic [D_W-1:0]     port_d_dir_i,
  input  logic [NEXT-1:0]    edge_sel_i,
  input  logic [MASK_W-1:0]  irq_mask_i,
  input  logic               arm_i,
  input  logic               reset_line_i,
  input  logic               dac_evt_i,
  input  logic               pdm_i,
  output logic [1:0]         sleep_state_o,
  output logic [NUM_TMR-1:0] tmr_en_o,
  output logic               wake_o
);
  import lpm_wake_pkg::*;

  sleep_st_e   state;
  logic [NEXT-1:0] ext_edge;
  logic [NEXT-1:0] ext_is_in;
  logic        rst_edge;
  logic        tmr_hit, ext_hit, rst_hit, dac_hit, wake_req;

  assign ext_is_in = {~port_d_dir_i, {F_W{1'b1}}};

  lpm_edge_sync #(.W(NEXT), .STAGES(SYNC_STAGES)) u_ext_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .pin_i      ({port_d_i, port_f_i}),
    .fall_sel_i (edge_sel_i),
    .edge_o     (ext_edge)
  );

  lpm_edge_sync #(.W(1), .STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .pin_i      (reset_line_i),
    .fall_sel_i (1'b0),
    .edge_o     (rst_edge)
  );

  assign tmr_en_o = f_timers_live(state) ? tmr_run_i : '0;

  lpm_wake_src #(.NUM_TMR(NUM_TMR), .NEXT(NEXT)) u_src (
    .state_i     (state),
    .tmr_en_i    (tmr_en_o),
    .tmr_uflow_i (tmr_uflow_i),
    .ext_edge_i  (ext_edge),
    .ext_is_in_i (ext_is_in),
    .mask_i      (irq_mask_i),
    .arm_i       (arm_i),
    .rst_edge_i  (rst_edge),
    .dac_evt_i   (dac_evt_i),
    .pdm_i       (pdm_i),
    .tmr_hit_o   (tmr_hit),
    .ext_hit_o   (ext_hit),
    .rst_hit_o   (rst_hit),
    .dac_hit_o   (dac_hit),
    .wake_req_o  (wake_req)
  );

  lpm_sleep_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .idle_i     (idle_i),
    .mode_i     (sleep_mode_i),
    .wake_req_i (wake_req),
    .state_o    (state),
    .wake_o     (wake_o)
  );

  assign sleep_state_o = state;
endmodule

// File: rtl/lpm_wake_chk.sv
module lpm_wake_chk #(
  parameter int NUM_TMR = 2,
  parameter int MASK_W  = 14
) (
  input logic               clk,
  input logic               rst_n,
  input logic               idle_i,
  input logic [NUM_TMR-1:0] tmr_run_i,
  input logic [NUM_TMR-1:0] tmr_uflow_i,
  input logic [MASK_W-1:0]  irq_mask_i,
  input logic [1:0]         sleep_state_o,
  input logic [NUM_TMR-1:0] tmr_en_o,
  input logic               wake_o,
  input logic               ext_hit,
  input logic               rst_hit,
  input logic               dac_hit
);
  logic light_mid;
  assign light_mid = (sleep_state_o == 2'd1) || (sleep_state_o == 2'd2);

  a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |=> !wake_o);

  a_r11_wake_on_exit: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |-> (sleep_state_o == 2'd0) && ($past(sleep_state_o) != 2'd0));

  a_r2_run_needs_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_state_o == 2'd0 && !idle_i) |=> (sleep_state_o == 2'd0));

  a_r2_idle_enters: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_state_o == 2'd0 && idle_i) |=> (sleep_state_o != 2'd0));

  a_r3_deep_stops_timers: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_state_o == 2'd3) |-> (tmr_en_o == '0));

  a_r3_shallow_keeps_timers: assert property (@(posedge clk) disable iff (!rst_n)
    light_mid |-> (tmr_en_o == tmr_run_i));

  a_r4_timer_wakes: assert property (@(posedge clk) disable iff (!rst_n)
    (light_mid && |(tmr_uflow_i & tmr_run_i & irq_mask_i[NUM_TMR-1:0])) |=> wake_o);

  a_r5_deep_no_timer_wake: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_state_o == 2'd3 && !ext_hit && !rst_hit && !dac_hit) |=> !wake_o);
endmodule

bind lpm_wake_ctrl lpm_wake_chk #(.NUM_TMR(NUM_TMR), .MASK_W(MASK_W)) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .idle_i        (idle_i),
  .tmr_run_i     (tmr_run_i),
  .tmr_uflow_i   (tmr_uflow_i),
  .irq_mask_i    (irq_mask_i),
  .sleep_state_o (sleep_state_o),
  .tmr_en_o      (tmr_en_o),
  .wake_o        (wake_o),
  .ext_hit       (ext_hit),
  .rst_hit       (rst_hit),
  .dac_hit       (dac_hit)
);

// File: tb/lpm_wake_ctrl_tb_top.sv
`timescale 1ns/1ps
module lpm_wake_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        idle_i = 1'b0;
  logic [1:0]  sleep_mode_i = '0;
  logic [1:0]  tmr_run_i = '0;
  logic [1:0]  tmr_uflow_i = '0;
  logic [7:0]  port_f_i = '0;
  logic [3:0]  port_d_i = '0;
  logic [3:0]  port_d_dir_i = '0;
  logic [11:0] edge_sel_i = '0;
  logic [13:0] irq_mask_i = '0;
  logic        arm_i = 1'b0;
  logic        reset_line_i = 1'b0;
  logic        dac_evt_i = 1'b0;
  logic        pdm_i = 1'b0;
  logic [1:0]  sleep_state_o;
  logic [1:0]  tmr_en_o;
  logic        wake_o;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lpm_wake_ctrl dut_i (.*);

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic enter(input logic [1:0] mode, input int exp_state, input string req);
    @(negedge clk);
    sleep_mode_i = mode; idle_i = 1'b1;
    @(negedge clk);
    idle_i = 1'b0;
    chk(req, "sleep state after idle", sleep_state_o, exp_state);
  endtask

  task automatic expect_woken(input string req);
    chk(req, "wake pulse", wake_o, 1);
    chk(req, "state back to run", sleep_state_o, 0);
    @(negedge clk);
    chk("R11", "pulse is single", wake_o, 0);
  endtask

  task automatic t_reset;
    tmr_run_i = 2'b10;
    #1;
    chk("R1", "state in reset", sleep_state_o, 0);
    chk("R1", "wake in reset", wake_o, 0);
    chk("R1", "timer enables", tmr_en_o, 2);
    cycles(2); rst_n = 1'b1; cycles(4);
    chk("R1", "state after reset", sleep_state_o, 0);
  endtask

  task automatic t_modes;
    tmr_run_i = 2'b11;
    enter(2'd0, 1, "R2");
    chk("R3", "light keeps timers", tmr_en_o, 3);
    idle_i = 1'b1; sleep_mode_i = 2'd2; @(negedge clk); idle_i = 1'b0;
    chk("R2", "idle while asleep ignored", sleep_state_o, 1);
    dac_evt_i = 1'b1; pdm_i = 1'b1; @(negedge clk); dac_evt_i = 1'b0;
    expect_woken("R10");
    enter(2'd1, 2, "R2");
    chk("R3", "mid keeps timers", tmr_en_o, 3);
    dac_evt_i = 1'b1; @(negedge clk); dac_evt_i = 1'b0;
    expect_woken("R10");
    enter(2'd2, 3, "R2");
    chk("R3", "deep stops timers", tmr_en_o, 0);
    dac_evt_i = 1'b1; @(negedge clk); dac_evt_i = 1'b0;
    expect_woken("R10");
    enter(2'd3, 3, "R2");
    dac_evt_i = 1'b1; @(negedge clk); dac_evt_i = 1'b0;
    expect_woken("R10");
    chk("R1", "enables restored in run", tmr_en_o, 3);
    pdm_i = 1'b0;
  endtask

  task automatic t_timer;
    tmr_run_i = 2'b01; irq_mask_i = 14'b10;
    enter(2'd0, 1, "R4");
    tmr_uflow_i = 2'b10; @(negedge clk); tmr_uflow_i = '0;
    chk("R4", "stopped timer no wake", sleep_state_o, 1);
    tmr_uflow_i = 2'b01; @(negedge clk); tmr_uflow_i = '0;
    chk("R4", "unmasked timer no wake", sleep_state_o, 1);
    irq_mask_i = 14'b01;
    tmr_uflow_i = 2'b01; @(negedge clk); tmr_uflow_i = '0;
    expect_woken("R4");
    tmr_run_i = 2'b11; irq_mask_i = 14'b11;
    enter(2'd1, 2, "R4");
    tmr_uflow_i = 2'b10; @(negedge clk); tmr_uflow_i = '0;
    expect_woken("R4");
    enter(2'd2, 3, "R5");
    tmr_uflow_i = 2'b11; @(negedge clk); tmr_uflow_i = '0; cycles(3);
    chk("R5", "deep ignores underflow", sleep_state_o, 3);
    chk("R5", "no wake in deep", wake_o, 0);
    dac_evt_i = 1'b1; pdm_i = 1'b1; @(negedge clk); dac_evt_i = 1'b0; pdm_i = 1'b0;
    expect_woken("R10");
    irq_mask_i = '0;
  endtask

  task automatic t_ext;
    irq_mask_i = '1; arm_i = 1'b1; edge_sel_i = '0;
    enter(2'd2, 3, "R6");
    port_f_i[5] = 1'b1;
    cycles(2);
    chk("R6", "no wake before sync delay", wake_o, 0);
    @(negedge clk);
    expect_woken("R6");
    edge_sel_i[9] = 1'b1; port_d_i[1] = 1'b1; cycles(5);
    enter(2'd0, 1, "R7");
    port_d_i[1] = 1'b0; cycles(5);
    chk("R7", "falling-edge pin ignores rise in run, wakes on fall", sleep_state_o, 0);
    enter(2'd0, 1, "R7");
    port_d_i[1] = 1'b1; cycles(5);
    chk("R7", "rise on falling-select pin ignored", sleep_state_o, 1);
    port_d_i[1] = 1'b0; cycles(3);
    expect_woken("R7");
    port_d_dir_i[3] = 1'b1;
    enter(2'd1, 2, "R8");
    port_d_i[3] = 1'b1; cycles(5);
    chk("R8", "output D pin ignored", sleep_state_o, 2);
    arm_i = 1'b0;
    port_f_i[0] = 1'b1; cycles(5);
    chk("R6", "arm clear blocks pin", sleep_state_o, 2);
    arm_i = 1'b1; irq_mask_i[2+1] = 1'b0;
    port_f_i[1] = 1'b1; cycles(5);
    chk("R6", "mask clear blocks pin", sleep_state_o, 2);
    port_d_i[2] = 1'b1; cycles(3);
    expect_woken("R6");
  endtask

  task automatic t_reset_line;
    irq_mask_i = '0; arm_i = 1'b0;
    enter(2'd3, 3, "R9");
    reset_line_i = 1'b1; cycles(2);
    chk("R9", "no wake before sync delay", wake_o, 0);
    @(negedge clk);
    expect_woken("R9");
    reset_line_i = 1'b0;
    enter(2'd0, 1, "R9");
    reset_line_i = 1'b1; cycles(3);
    expect_woken("R9");
    reset_line_i = 1'b0; cycles(4);
  endtask

  task automatic t_dac_off;
    pdm_i = 1'b0;
    enter(2'd1, 2, "R10");
    dac_evt_i = 1'b1; cycles(3); dac_evt_i = 1'b0;
    chk("R10", "DAC event with pdm clear ignored", sleep_state_o, 2);
    pdm_i = 1'b1; dac_evt_i = 1'b1; @(negedge clk); dac_evt_i = 1'b0; pdm_i = 1'b0;
    expect_woken("R10");
  endtask

  task automatic t_run_events;
    int pulses = 0;
    irq_mask_i = '1; arm_i = 1'b1; tmr_run_i = 2'b11; pdm_i = 1'b1;
    port_f_i = ~port_f_i; tmr_uflow_i = 2'b11; dac_evt_i = 1'b1; reset_line_i = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (wake_o) pulses++;
    end
    tmr_uflow_i = '0; dac_evt_i = 1'b0; reset_line_i = 1'b0; pdm_i = 1'b0;
    chk("R11", "no wake pulse from run", pulses, 0);
    chk("R11", "still in run", sleep_state_o, 0);
    cycles(4);
  endtask

  initial begin
    t_reset;
    t_modes;
    t_timer;
    t_ext;
    t_reset_line;
    t_dac_off;
    t_run_events;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule